// File: doc/BRIEF.md
# Framed Master-Mode Serial Output Port

This block sends one 16-bit result word to a serial receiver every 64 master clocks. It generates its own serial clock at half the master clock rate, a frame sync, and a serial data bit. The result is captured into a holding register by a load strobe. The shifter takes the held word only when a frame begins, so a word that arrives mid-frame is not torn. Each frame carries the word MSB first over 16 serial clocks, and then 16 serial clocks of zeros.

Two static pins set the frame sync style (a short pulse or a half-frame square wave) and invert the serial clock phase. An optional frame-sync input restarts the frame timing when it rises out of step with the word boundary. A resync flag then marks the following 127 words as invalid while the upstream filter refills. A compare between two select pins gives the data-line enable. This lets two ports share one line in alternate halves of a frame.

Top module: `ser_frame_tx`

## Requirements
- R1: `sclk_o` toggles on every master clock, so its frequency is half the master clock. Each serial clock period spans frame cycles 2k and 2k+1.
- R2: A frame is 64 master clocks long. Frame cycle 0 is the first clock after reset release. Bit 15−k of the frame's word is on `sdata_o` during frame cycles 2k and 2k+1, for k = 0..15.
- R3: During frame cycles 32 to 63, `sdata_o` is 0.
- R4: With `fsync_square_i` = 1, `fsync_o` is low in frame cycles 0–31 and high in frame cycles 32–63.
- R5: With `fsync_square_i` = 0, `fsync_o` is high in frame cycles 0 and 1 only.
- R6: With `sclk_invert_i` = 0, `sclk_o` behaves as follows. In pulse mode it is high in even frame cycles, so data changes on its rising edge. In square mode it is high in odd frame cycles, so data changes on its falling edge. Setting `sclk_invert_i` to 1 inverts `sclk_o` in both modes.
- R7: `sdata_oe_o` is 1 exactly when `oe_sel_i` equals `oe_match_i`.
- R8: A rising edge is defined as `fsi_i` sampled 1 on a clock edge after being sampled 0 on the previous edge; the first edge after reset does not count. If such a rising edge is sampled in any frame cycle other than 63, the next cycle becomes frame cycle 0, with the held word loaded. `resync_o` is then high for exactly 127×64 cycles, starting at that cycle.
- R9: A rising `fsi_i` sampled in frame cycle 63 changes neither the timing nor `resync_o`.
- R10: An `fsi_i` held at a constant level, including high through reset, never restarts the frame and never raises `resync_o`.
- R11: A word taken by `load_i` is transmitted from the next frame start. A load during a frame does not alter the word being sent in that frame.
- R12: While `rst_ni` is low the following hold: frame cycle is 0, the held and shifted words are 0, `sdata_o` is 0 and `resync_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 16 | Result word to transmit |
| load_i | input | 1 | Capture `word_i` into the holding register |
| fsync_square_i | input | 1 | 0: pulse frame sync, 1: square-wave frame sync |
| sclk_invert_i | input | 1 | Invert serial clock phase |
| fsi_i | input | 1 | External frame alignment input |
| oe_sel_i | input | 1 | Enable select, compared with `oe_match_i` |
| oe_match_i | input | 1 | Level that `oe_sel_i` must match to drive the line |
| sclk_o | output | 1 | Serial clock, half the master clock rate |
| sdata_o | output | 1 | Serial data |
| sdata_oe_o | output | 1 | Serial data line drive enable |
| fsync_o | output | 1 | Frame sync |
| resync_o | output | 1 | Words invalid after a realignment |

## Verification
The hardest state to reach is the end of the invalid window after a misaligned frame-sync edge. That window closes only after 127 complete frames, with no further edge on `fsi_i` in between. The stimulus raises `fsi_i` in frame cycle 20, then holds it high for more than 8128 cycles. It counts the cycles with `resync_o` high and checks timing, data and format on every one of those cycles. A second edge is placed exactly in frame cycle 63 to show the aligned case leaves the timing untouched. The reset is applied with `fsi_i` already high, to show that a constant level does not count as an edge.

// File: rtl/ser_frame_pkg.sv
package ser_frame_pkg;
  typedef enum logic {
    FS_PULSE  = 1'b0,
    FS_SQUARE = 1'b1
  } fs_style_e;
endpackage

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int FRAME_LEN  = 64,
  parameter int SKIP_WORDS = 127,
  localparam int CNT_W  = $clog2(FRAME_LEN),
  localparam int SKIP_W = $clog2(SKIP_WORDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsi_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             frame_start_o,
  output logic             resync_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [SKIP_W-1:0] skip_q;
  logic              fsi_q, seen_q;
  logic              fsi_rise, at_last, restart;

  assign fsi_rise      = seen_q & fsi_i & ~fsi_q;
  assign at_last       = (cnt_q == LAST);
  assign restart       = fsi_rise & ~at_last;
  assign frame_start_o = restart | at_last;
  assign cnt_o         = cnt_q;
  assign resync_o      = (skip_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      skip_q <= '0;
      fsi_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      fsi_q  <= fsi_i;
      cnt_q  <= restart ? '0 : cnt_q + 1'b1;
      if (restart)
        skip_q <= SKIP_W'(SKIP_WORDS);
      else if (at_last && skip_q != '0)
        skip_q <= skip_q - 1'b1;
    end
  end

  // R8
  resync_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resync_o) |-> cnt_q == '0);
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] word_i,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              frame_start_i,
  output logic              sdata_o
);
  logic [DATA_W-1:0] hold_q, sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      sh_q   <= '0;
    end else begin
      if (load_i) hold_q <= word_i;
      // zeros shift in behind the word, giving the idle half of the frame
      if (frame_start_i)  sh_q <= hold_q;
      else if (cnt_i[0])  sh_q <= {sh_q[DATA_W-2:0], 1'b0};
    end
  end

  assign sdata_o = sh_q[DATA_W-1];

  // R2
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i[0] |-> $stable(sdata_o));

  // R3
  idle_half_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i[CNT_W-1] |-> !sdata_o);
endmodule

// File: rtl/sync_format.sv
module sync_format
  import ser_frame_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             fsync_square_i,
  input  logic             sclk_invert_i,
  output logic             sclk_o,
  output logic             fsync_o
);
  fs_style_e style;
  logic      sclk_base;

  assign style = fs_style_e'(fsync_square_i);

  always_comb begin
    unique case (style)
      FS_SQUARE: begin
        sclk_base = cnt_i[0];
        fsync_o   = cnt_i[CNT_W-1];
      end
      default: begin
        sclk_base = ~cnt_i[0];
        fsync_o   = (cnt_i[CNT_W-1:1] == '0);
      end
    endcase
  end

  assign sclk_o = sclk_base ^ sclk_invert_i;
endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx #(
  parameter int DATA_W     = 16,
  parameter int SKIP_WORDS = 127
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] word_i,
  input  logic              load_i,
  input  logic              fsync_square_i,
  input  logic              sclk_invert_i,
  input  logic              fsi_i,
  input  logic              oe_sel_i,
  input  logic              oe_match_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              fsync_o,
  output logic              resync_o
);
  localparam int FRAME_LEN = 4 * DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN);

  logic [CNT_W-1:0] frame_cnt;
  logic             frame_start;

  frame_timer #(.FRAME_LEN(FRAME_LEN), .SKIP_WORDS(SKIP_WORDS)) u_timer (
    .clk_i, .rst_ni, .fsi_i,
    .cnt_o(frame_cnt), .frame_start_o(frame_start), .resync_o
  );

  word_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk_i, .rst_ni, .word_i, .load_i,
    .cnt_i(frame_cnt), .frame_start_i(frame_start), .sdata_o
  );

  sync_format #(.CNT_W(CNT_W)) u_fmt (
    .cnt_i(frame_cnt), .fsync_square_i, .sclk_invert_i, .sclk_o, .fsync_o
  );

  assign sdata_oe_o = (oe_sel_i == oe_match_i);

  // R1
  sclk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_cnt[0] && $stable(fsync_square_i) && $stable(sclk_invert_i)
      |-> sclk_o != $past(sclk_o));

  // R4
  square_mid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_square_i && $stable(fsync_square_i) && $rose(fsync_o)
      |-> frame_cnt == CNT_W'(FRAME_LEN / 2));
endmodule

// File: tb/ser_frame_tx_bench.sv
module ser_frame_tx_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, load, sfmt, cfmt, fsi, doe, tsi;
  logic [15:0] word;
  logic        sclk, sdata, sdata_oe, fsync, resync;
  int          checks = 0, fails = 0;

  ser_frame_tx u_ser_frame_tx (
    .clk_i(clk), .rst_ni(rst_n), .word_i(word), .load_i(load),
    .fsync_square_i(sfmt), .sclk_invert_i(cfmt), .fsi_i(fsi),
    .oe_sel_i(doe), .oe_match_i(tsi),
    .sclk_o(sclk), .sdata_o(sdata), .sdata_oe_o(sdata_oe),
    .fsync_o(fsync), .resync_o(resync)
  );

  // reference model of frame timing, built from the requirements
  int          m_cnt, m_skip;
  logic        m_fsi_q, m_seen, m_rise;
  logic [15:0] m_hold, m_word;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_skip <= 0; m_fsi_q <= 0; m_seen <= 0;
      m_hold <= '0; m_word <= '0;
    end else begin
      m_rise = m_seen && fsi && !m_fsi_q;
      m_seen  <= 1'b1;
      m_fsi_q <= fsi;
      if (load) m_hold <= word;
      if (m_rise && m_cnt != 63) begin
        m_cnt <= 0; m_skip <= 127; m_word <= m_hold;
      end else begin
        m_cnt <= (m_cnt + 1) % 64;
        if (m_cnt == 63) begin
          m_word <= m_hold;
          if (m_skip > 0) m_skip <= m_skip - 1;
        end
      end
    end
  end

  localparam logic [17:0] VEC [6] = '{
    18'h0A5C3, 18'h18001, 18'h27FFE, 18'h3FFFF, 18'h00000, 18'h21234
  };

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at t=%0t cnt=%0d: actual %b expected %b", req, $time, m_cnt, act, exp);
    end
  endtask

  task automatic check_cycle();
    logic e_sd, e_fs, e_sc;
    e_sd = (m_cnt < 32) ? m_word[15 - m_cnt / 2] : 1'b0;
    e_fs = sfmt ? (m_cnt >= 32) : (m_cnt < 2);
    e_sc = (sfmt ? (m_cnt % 2 == 1) : (m_cnt % 2 == 0)) ^ cfmt;
    chk((m_cnt < 32) ? "R2 sdata" : "R3 sdata", sdata, e_sd);
    chk(sfmt ? "R4 fsync" : "R5 fsync", fsync, e_fs);
    chk("R1/R6 sclk", sclk, e_sc);
    chk("R8 resync", resync, m_skip != 0);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      check_cycle();
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; load = 0; word = '0; sfmt = 0; cfmt = 0; fsi = 1; doe = 0; tsi = 0;
    repeat (3) @(negedge clk);
    #1;
    // R12 reset state
    chk("R12 sdata", sdata, 1'b0);
    chk("R12 resync", resync, 1'b0);
    chk("R12 fsync", fsync, 1'b1);
    @(negedge clk); rst_n = 1;

    // R10: fsi high through reset, held constant
    step(200);
    chk("R10 resync", resync, 1'b0);

    // vector table: format and word per entry, R11 with mid-frame load
    for (int v = 0; v < 6; v++) begin
      sfmt = VEC[v][17]; cfmt = VEC[v][16]; word = VEC[v][15:0];
      load = 1; step(1); load = 0;
      while (m_cnt != 0) step(1);
      for (int c = 0; c < 64; c++) begin
        if (c == 10) begin word = ~VEC[v][15:0]; load = 1; end
        if (c == 11) load = 0;
        step(1);
      end
      // R11: the mid-frame word now goes out
      chk("R11 next-frame msb", sdata, ~VEC[v][15]);
      step(64);
    end

    // R7 enable compare
    for (int k = 0; k < 4; k++) begin
      doe = k[0]; tsi = k[1]; #1;
      chk("R7 oe", sdata_oe, doe == tsi);
    end

    // R9 aligned rising edge at frame cycle 63
    sfmt = 0; cfmt = 0; fsi = 0; step(2);
    while (m_cnt != 63) step(1);
    fsi = 1; step(1);
    chk("R9 resync", resync, 1'b0);
    chk("R9 frame start fsync", fsync, 1'b1);
    step(64);

    // R8 misaligned edge at frame cycle 20
    sfmt = 1; fsi = 0; step(2);
    while (m_cnt != 20) step(1);
    fsi = 1; step(1);
    chk("R8 restart fsync low", fsync, 1'b0);
    chk("R8 resync raised", resync, 1'b1);
    begin
      int hi;
      hi = 1;
      for (int i = 0; i < 127 * 64 + 70; i++) begin
        step(1);
        if (resync) hi++;
      end
      checks++;
      if (hi != 127 * 64) begin
        fails++;
        $display("FAIL R8 window: actual %0d expected %0d", hi, 127 * 64);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule